// File: doc/BRIEF.md
# Double-Buffered 8-bit PWM Timer

This block is an 8-bit up-counting timer that runs in pulse-width-modulation mode. A prescaler turns the system clock into a count tick at one of four rates. The counter advances by one on each tick and runs through all 256 states, so one output period always lasts 256 ticks. An output flip-flop inverts when the count reaches the active compare value and inverts again when the counter wraps from 255 to 0. The output pin drives the inverse of that flip-flop. A one-clock interrupt strobe marks each wrap.

Software writes the compare value into a staging register. The value moves into the active compare register only at a wrap or when the timer starts. A new duty therefore never disturbs the period that is in progress, and software can reload it from the wrap interrupt without glitches. Clearing the run bit stops the timer, clears the counter and the flip-flop, and keeps the staged value so the next start can pick it up.

Top module: `pwm8_timer`

## Requirements
- R1: While running, the 8-bit counter goes up by exactly one on each tick and wraps from 255 to 0. Without a tick it does not change.
- R2: On a tick that brings the count equal to the active compare value, the output flip-flop inverts and the counter keeps counting without clearing. At tick rate divide-by-1 and compare value n (1..255), the pin is high for n clocks of each period, starting at the wrap.
- R3: On the tick that wraps the counter from 255 to 0, the flip-flop inverts and `period_irq` is high for exactly one clock, during the clock after that edge. At that point the counter reads 0.
- R4: `pwm_out` is the inverse of the flip-flop, so after reset and after each start the pin is 1 until the first compare match.
- R5: A write on `cmp_wr_en` only loads the staging register. The active compare value changes only at a wrap or at a start, so a write never alters the period in progress.
- R6: The clock edge at which `run` is first seen as 1 copies the staging register into the active register. Counting begins on the following clock, so the first period already uses the value written before the start.
- R7: While `run` is 0, the counter, the prescaler and the flip-flop are held at 0, so the pin is 1 and no strobe occurs. The staging register keeps its value.
- R8: `src_sel` codes 0, 1, 2 and 3 give a tick every 8, 4, 2 and 1 clocks. A period therefore lasts 2048, 1024, 512 and 256 clocks.
- R9: `src_sel` codes 4 to 7 produce no ticks. The counter, the pin and the strobe then hold still, even though `run` is 1.
- R10: If a write and a wrap transfer fall on the same clock, the transfer takes the previously staged value. The new value becomes active at the following wrap.
- R11: A compare value of 0 makes the match coincide with the wrap. The two inversions cancel, and the pin stays at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start (1) / stop (0) control |
| src_sel | input | 3 | Tick rate select: 0=/8, 1=/4, 2=/2, 3=/1, 4..7=no tick |
| cmp_wr_en | input | 1 | Write strobe for the compare staging register |
| cmp_wr_data | input | 8 | Compare data written into the staging register |
| pwm_out | output | 1 | PWM pin level, inverse of the output flip-flop |
| period_irq | output | 1 | One-clock strobe at each counter wrap |

## Verification
The assertions check on every clock that the counter steps by one per tick, that a match never clears it, that the strobe lasts one clock and lines up with a zero count, and that the active compare value is frozen except at a load. They also check that a load colliding with a write takes the old staged value, that a stop clears the count and restores the pin, and that the hold codes freeze the count. Only the bench scenarios can show the measured results: the pin widths for particular compare values, the period length at each tick rate, the constant pin at compare value 0, and a restart that picks up a value staged while the timer was stopped. The bench's cycle model also covers a write that lands exactly on the wrap edge.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  localparam int CNT_W = 8;
  localparam int SEL_W = 3;
  localparam int PRE_W = 3;
  localparam int NUM_TAPS = 4;

  // A tap code selects a divider of 2**(PRE_W - code).
  function automatic logic sel_is_tap(input logic [SEL_W-1:0] sel);
    return int'(sel) < NUM_TAPS;
  endfunction

  // All-ones mask of the low prescaler bits for the chosen divider.
  function automatic logic [PRE_W-1:0] tap_mask(input logic [SEL_W-1:0] sel);
    logic [PRE_W-1:0] m;
    m = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < PRE_W - int'(sel)) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction
endpackage

// File: rtl/pwm8_prescaler.sv
module pwm8_prescaler
  import pwm8_pkg::*;
#(
  parameter int PW = PRE_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [SW-1:0] sel,
  output logic          tick
);
  logic [PW-1:0] div_q;
  logic [PW-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (!enable) div_q <= '0;
    else              div_q <= div_q + PW'(1);
  end

  assign mask = tap_mask(sel);
  assign tick = enable && sel_is_tap(sel) && ((div_q & mask) == mask);

  // R9: codes outside the tap range never tick
  p_no_tick_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[SW-1] |-> !tick));
endmodule

// File: rtl/pwm8_counter.sv
module pwm8_counter
  import pwm8_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] active,
  output logic [W-1:0] cnt,
  output logic         match_evt,
  output logic         ovf_evt,
  output logic         ff
);
  logic [W-1:0] nxt;

  assign nxt       = count_next(cnt);
  assign match_evt = tick && (nxt == active);
  assign ovf_evt   = tick && (cnt == {W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ff <= 1'b0;
    else if (!run) ff <= 1'b0;
    else           ff <= ff ^ match_evt ^ ovf_evt;
  end

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!run || cnt == W'($past(cnt) + W'(1))));

  p_count_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && run) |=> (!run || $stable(cnt)));

  p_match_no_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !ovf_evt) |=> (!run || cnt != '0));

  p_zero_cmp_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && ovf_evt) |=> (!run || ff == $past(ff)));
endmodule

// File: rtl/pwm8_cmp_buffer.sv
module pwm8_cmp_buffer
  import pwm8_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         load,
  output logic [W-1:0] active
);
  logic [W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stage_q <= '0;
    else if (wr_en) stage_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    active <= '0;
    else if (load) active <= stage_q;
  end

  p_active_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active));

  p_collide_old_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && wr_en) |=> (active == $past(stage_q)));
endmodule

// File: rtl/pwm8_timer.sv
module pwm8_timer
  import pwm8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             cmp_wr_en,
  input  logic [CNT_W-1:0] cmp_wr_data,
  output logic             pwm_out,
  output logic             period_irq
);
  logic             armed_q;
  logic             counting;
  logic             start_evt;
  logic             tick;
  logic             match_evt;
  logic             ovf_evt;
  logic             ff;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= run;
  end

  assign counting  = run && armed_q;
  assign start_evt = run && !armed_q;

  pwm8_prescaler #(.PW(PRE_W), .SW(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .enable(counting), .sel(src_sel), .tick(tick)
  );

  pwm8_cmp_buffer #(.W(CNT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(cmp_wr_en), .wr_data(cmp_wr_data),
    .load(ovf_evt || start_evt), .active(active)
  );

  pwm8_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .active(active),
    .cnt(cnt), .match_evt(match_evt), .ovf_evt(ovf_evt), .ff(ff)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) period_irq <= 1'b0;
    else        period_irq <= ovf_evt && run;
  end

  assign pwm_out = ~ff;

  p_irq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    period_irq |=> !period_irq);

  p_irq_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    period_irq |-> (cnt == '0));

  p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && pwm_out && !period_irq));

  p_hold_codes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && src_sel[SEL_W-1]) |=> (!run || ($stable(cnt) && $stable(pwm_out))));

  p_start_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (cnt == '0 && pwm_out));
endmodule

// File: tb/sim_pwm8_timer.sv
module sim_pwm8_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [2:0] src_sel = 3'd3;
  logic       cmp_wr_en = 1'b0;
  logic [7:0] cmp_wr_data = 8'd0;
  logic       pwm_out;
  logic       period_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm8_timer u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .src_sel(src_sel),
    .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
    .pwm_out(pwm_out), .period_irq(period_irq)
  );

  // Behavioural reference: integers only
  int m_armed = 0, m_phase = 0, m_cnt = 0, m_ff = 0, m_irq = 0;
  int m_stage = 0, m_act = 0;

  always @(posedge clk) begin
    int old_stage;
    int d;
    old_stage = m_stage;
    if (!rst_n) begin
      m_armed = 0; m_phase = 0; m_cnt = 0; m_ff = 0; m_irq = 0;
      m_stage = 0; m_act = 0;
    end else begin
      m_irq = 0;
      if (!run) begin
        m_armed = 0; m_phase = 0; m_cnt = 0; m_ff = 0;
      end else if (m_armed == 0) begin
        m_armed = 1; m_act = old_stage;
      end else begin
        if (src_sel < 4) begin
          d = 8 >> src_sel;
          if ((m_phase % d) == d - 1) begin
            if (((m_cnt + 1) % 256) == m_act) m_ff = 1 - m_ff;
            if (m_cnt == 255) begin
              m_ff = 1 - m_ff; m_irq = 1; m_act = old_stage;
            end
            m_cnt = (m_cnt + 1) % 256;
          end
        end
        m_phase = m_phase + 1;
      end
      if (cmp_wr_en) m_stage = cmp_wr_data;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      checks++;
      if (pwm_out !== (m_ff == 0) || period_irq !== (m_irq == 1)) begin
        errors++;
        $display("FAIL R2,R3,R5 model: pwm=%0b irq=%0b expected pwm=%0b irq=%0b at cycle %0d",
                 pwm_out, period_irq, m_ff == 0, m_irq, cycles);
      end
    end
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected < 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cmp(input int v);
    cmp_wr_en = 1'b1; cmp_wr_data = 8'(v);
    @(negedge clk);
    cmp_wr_en = 1'b0;
  endtask

  task automatic wait_irq(output int waited);
    waited = 0;
    while (!period_irq && waited < 5000) begin
      @(negedge clk); waited++;
    end
  endtask

  // Called at the negedge where period_irq is seen: counts high pin samples
  task automatic measure_high(output int n);
    n = 0;
    while (pwm_out && n < 300) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic measure_period(output int p);
    int w;
    wait_irq(w);
    @(negedge clk);
    p = 1;
    while (!period_irq && p < 5000) begin
      @(negedge clk); p++;
    end
  endtask

  initial begin
    int w, n, p, irqs, highs;
    repeat (3) @(negedge clk);
    check("R4 reset pin", int'(pwm_out), 1);
    check("R3 reset irq", int'(period_irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: value staged before start used in first period
    src_sel = 3'd3;
    write_cmp(64);
    run = 1'b1;
    @(negedge clk);
    n = 0;
    while (pwm_out && n < 300) begin @(negedge clk); n++; end
    check("R6 first period high (start sample incl.)", n, 64);
    wait_irq(w);
    measure_high(n);
    check("R2 high width n=64", n, 64);

    // R5: mid-period write does not alter the current period
    write_cmp(200);
    wait_irq(w);
    measure_high(n);
    check("R5 new value after wrap", n, 200);

    // R10: write on the wrap edge
    wait_irq(w);
    repeat (255) @(negedge clk);
    write_cmp(30);
    wait_irq(w);
    measure_high(n);
    check("R10 collided write not yet active", n, 200);
    wait_irq(w);
    measure_high(n);
    check("R10 collided write active next", n, 30);

    // R8: period lengths per tap
    src_sel = 3'd3; measure_period(p); measure_period(p);
    check("R8 div1 period", p, 256);
    src_sel = 3'd2; measure_period(p); measure_period(p);
    check("R8 div2 period", p, 512);
    src_sel = 3'd1; measure_period(p); measure_period(p);
    check("R8 div4 period", p, 1024);
    src_sel = 3'd0; measure_period(p); measure_period(p);
    check("R8 div8 period", p, 2048);
    wait_irq(w);
    check("R3 irq width one clock (seen)", int'(period_irq), 1);
    @(negedge clk);
    check("R3 irq drops after one clock", int'(period_irq), 0);

    // R9: hold codes freeze everything
    src_sel = 3'd3;
    repeat (20) @(negedge clk);
    src_sel = 3'd6;
    @(negedge clk);
    irqs = 0; highs = 0;
    for (int i = 0; i < 600; i++) begin
      if (period_irq) irqs++;
      if (pwm_out) highs++;
      @(negedge clk);
    end
    check("R9 no strobe on hold code", irqs, 0);
    check("R9 pin frozen on hold code", (highs == 0 || highs == 600) ? 1 : 0, 1);

    // R7: stop clears, staged value kept across stop
    src_sel = 3'd3;
    repeat (40) @(negedge clk);
    run = 1'b0;
    write_cmp(100);
    irqs = 0; highs = 0;
    for (int i = 0; i < 300; i++) begin
      if (period_irq) irqs++;
      if (pwm_out) highs++;
      @(negedge clk);
    end
    check("R7 pin high while stopped", highs, 300);
    check("R7 no strobe while stopped", irqs, 0);
    run = 1'b1;
    @(negedge clk);
    n = 0;
    while (pwm_out && n < 300) begin @(negedge clk); n++; end
    check("R7 staged value kept over stop", n, 100);

    // R1: free count gives periodic strobes 256 apart at div1
    measure_period(p);
    check("R1 count wraps after 256 ticks", p, 256);

    // R11: compare value 0 keeps pin high
    write_cmp(0);
    wait_irq(w);
    @(negedge clk);
    highs = 0;
    for (int i = 0; i < 600; i++) begin
      if (pwm_out) highs++;
      @(negedge clk);
    end
    check("R11 zero compare pin stays high", highs, 600);

    run = 1'b0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule